// File: doc/BRIEF.md
# Shallow FIFO with Selectable Output Hold Register

This block is a sixteen-entry synchronous queue with a single write port and a single read port on one clock. Its data output is not a registered read port. The output is taken combinationally from the storage slot that sits just behind the read pointer, so after a read the output shows the word that was just removed from the queue. That word stays on the output while the read pointer does not move.

The read slot is not protected, and this causes a boundary effect. If a read empties the queue and sixteen writes then follow, the last of those writes lands in the slot that was read most recently. The output then changes to the new word. To keep the output steady, the user can raise a latch-select input. A holding register captures each word as it is read, and the output is then driven from that register, so the full-filling write no longer disturbs it. A system that leaves the latch off and needs a stable output must stop writing one cycle before the queue becomes full.

Top module: `shallow_fifo_hold`

## Requirements
- R1: After synchronous reset, empty is 1, full is 0 and data_out is 0x00 with both pointers at slot 0.
- R2: Each write accepted while not full stores one word. full rises after the sixteenth write stored since the queue was last empty, and full and empty are never 1 together.
- R3: With hold_sel=0, a read accepted while not empty puts the word read on data_out from the next cycle. Words come out in the order written, and the word stays on data_out until the next accepted read.
- R4: A write request while full is ignored. full stays 1, and the next sixteen reads return only the sixteen stored words.
- R5: A read request while empty is ignored. empty stays 1 and data_out is unchanged.
- R6: With hold_sel=0, when a read leaves the queue empty, the sixteenth write that follows overwrites the last-read slot. data_out changes to the word of that write in the cycle after it.
- R7: With hold_sel=1, data_out keeps the last word read through all sixteen refilling writes, including the one that sets full.
- R8: A read and a write requested in one cycle, with the queue neither empty nor full, are both accepted. The occupancy and the flags stay unchanged, and the word read appears on data_out.
- R9: With hold_sel=1, the holding register loads the word taken by each accepted read. data_out shows that word from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Word to store |
| rd_en | input | 1 | Read request |
| hold_sel | input | 1 | 1 selects the holding register as the output source |
| data_out | output | 8 | Last word read, from the slot behind the read pointer or from the holding register |
| full | output | 1 | Sixteen words stored |
| empty | output | 1 | No word stored |

## Verification
Two kinds of event can fall in the same cycle: an accepted read and an accepted write, and a write that refills the queue while the last-read slot still drives the output. The bench raises both requests together at a mid-level occupancy. It checks that the flags stay put and that the word read still arrives. It also fills the queue from empty after a read, once with the hold register off and once with it on. With the register off, the output must switch to the sixteenth word. With the register on, the output must keep the old word.

// File: rtl/fifo_hold_pkg.sv
package fifo_hold_pkg;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PTR_W  = ADDR_W + 1;
    localparam int DATA_W = 8;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        addr_t wr_addr;
        addr_t rd_addr;
        addr_t last_addr;
        logic  wr_go;
        logic  rd_go;
        logic  full;
        logic  empty;
    } ctl_t;

    function automatic addr_t slot_of(ptr_t p);
        return p[ADDR_W-1:0];
    endfunction

    function automatic logic ptr_full(ptr_t w, ptr_t r);
        return (w[PTR_W-1] != r[PTR_W-1]) && (slot_of(w) == slot_of(r));
    endfunction
endpackage

// File: rtl/fifo_hold_ptr.sv
module fifo_hold_ptr
    import fifo_hold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic rd_en,
    output ctl_t ctl
);
    ptr_t wp_q, rp_q;
    logic full_w, empty_w, wr_go, rd_go;

    assign full_w  = ptr_full(wp_q, rp_q);
    assign empty_w = (wp_q == rp_q);
    assign wr_go   = wr_en && !full_w;
    assign rd_go   = rd_en && !empty_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_go) wp_q <= wp_q + ptr_t'(1);
            if (rd_go) rp_q <= rp_q + ptr_t'(1);
        end
    end

    always_comb begin
        ctl.wr_addr   = slot_of(wp_q);
        ctl.rd_addr   = slot_of(rp_q);
        ctl.last_addr = slot_of(rp_q) - addr_t'(1);
        ctl.wr_go     = wr_go;
        ctl.rd_go     = rd_go;
        ctl.full      = full_w;
        ctl.empty     = empty_w;
    end
endmodule

// File: rtl/fifo_hold_store.sv
module fifo_hold_store
    import fifo_hold_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr_a,
    input  addr_t raddr_b,
    output word_t rdata_a,
    output word_t rdata_b
);
    word_t cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[i] <= '0;
            else if (we && (waddr == addr_t'(i)))
                cells[i] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/fifo_hold_out.sv
module fifo_hold_out
    import fifo_hold_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t head_word,
    input  word_t behind_word,
    input  logic  sel_hold,
    output word_t dout
);
    word_t hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (load)
            hold_q <= head_word;
    end

    assign dout = sel_hold ? hold_q : behind_word;
endmodule

// File: rtl/shallow_fifo_hold.sv
module shallow_fifo_hold
    import fifo_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    input  logic        hold_sel,
    output logic [7:0]  data_out,
    output logic        full,
    output logic        empty
);
    ctl_t  ctl;
    word_t head_w, behind_w;

    fifo_hold_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .ctl   (ctl)
    );

    fifo_hold_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.wr_go),
        .waddr   (ctl.wr_addr),
        .wdata   (wr_data),
        .raddr_a (ctl.rd_addr),
        .raddr_b (ctl.last_addr),
        .rdata_a (head_w),
        .rdata_b (behind_w)
    );

    fifo_hold_out u_out (
        .clk         (clk),
        .rst         (rst),
        .load        (ctl.rd_go),
        .head_word   (head_w),
        .behind_word (behind_w),
        .sel_hold    (hold_sel),
        .dout        (data_out)
    );

    assign full  = ctl.full;
    assign empty = ctl.empty;
endmodule

// File: rtl/fifo_hold_chk.sv
module fifo_hold_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       hold_sel,
    input logic [7:0] data_out,
    input logic       full,
    input logic       empty
);
    a_r1_reset_flags: assert property (@(posedge clk)
        rst |=> (empty && !full && data_out == 8'h00));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r4_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> full);

    a_r5_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(data_out)));

    a_r8_simul_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> (!full && !empty));

    a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (hold_sel && !rd_en) |=> (!hold_sel || $stable(data_out)));
endmodule

bind shallow_fifo_hold fifo_hold_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .hold_sel (hold_sel),
    .data_out (data_out),
    .full     (full),
    .empty    (empty)
);

// File: tb/sim_shallow_fifo_hold.sv
module sim_shallow_fifo_hold;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       hold_sel = 1'b0;
    logic [7:0] data_out;
    logic       full, empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shallow_fifo_hold u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .hold_sel(hold_sel),
        .data_out(data_out), .full(full), .empty(empty)
    );

    // fields: [20] we, [19:12] wdata, [11] re, [10] hold_sel,
    //         [9:2] expected data_out, [1] expected empty, [0] expected full
    localparam int NV = 6;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'hAA, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R2 write into empty
        {1'b0, 8'h00, 1'b1, 1'b0, 8'hAA, 1'b1, 1'b0},  // R3 read shows word
        {1'b0, 8'h00, 1'b1, 1'b0, 8'hAA, 1'b1, 1'b0},  // R5 read on empty
        {1'b1, 8'h11, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b0},  // R3 output stays
        {1'b1, 8'h22, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0},  // R8 read+write
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h22, 1'b1, 1'b0}   // R3 order kept
    };

    task automatic check(string req, logic [7:0] d, logic e, logic f,
                         logic [7:0] ed, logic ee, logic ef);
        checks++;
        if (d !== ed || e !== ee || f !== ef) begin
            errors++;
            $display("FAIL %s: data_out=%h empty=%b full=%b expected data_out=%h empty=%b full=%b",
                     req, d, e, f, ed, ee, ef);
        end
    endtask

    task automatic cyc(logic we, logic [7:0] wd, logic re);
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1", data_out, empty, full, 8'h00, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            hold_sel = VEC[i][10];
            cyc(VEC[i][20], VEC[i][19:12], VEC[i][11]);
            check($sformatf("R3/R5/R8 vector %0d", i), data_out, empty, full,
                  VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R6: refill after read, latch off
        hold_sel = 1'b0;
        do_reset();
        check("R1", data_out, empty, full, 8'h00, 1'b1, 1'b0);
        cyc(1'b1, 8'hAA, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R3", data_out, empty, full, 8'hAA, 1'b1, 1'b0);
        for (int i = 1; i <= 15; i++) cyc(1'b1, 8'(i), 1'b0);
        check("R6 before 16th write", data_out, empty, full, 8'hAA, 1'b0, 1'b0);
        cyc(1'b1, 8'h5A, 1'b0);
        check("R6 16th write overwrites", data_out, empty, full, 8'h5A, 1'b0, 1'b1);
        check("R2 full after 16", data_out, empty, full, 8'h5A, 1'b0, 1'b1);
        cyc(1'b1, 8'hEE, 1'b0);
        check("R4 write when full", data_out, empty, full, 8'h5A, 1'b0, 1'b1);
        for (int i = 1; i <= 16; i++) begin
            cyc(1'b0, 8'h00, 1'b1);
            check($sformatf("R4 drain %0d", i), data_out, empty, full,
                  (i == 16) ? 8'h5A : 8'(i), (i == 16), 1'b0);
        end
        cyc(1'b0, 8'h00, 1'b1);
        check("R5 read on empty", data_out, empty, full, 8'h5A, 1'b1, 1'b0);

        // R7 / R9: latch on
        do_reset();
        hold_sel = 1'b1;
        cyc(1'b1, 8'hAA, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        check("R9 hold loads read word", data_out, empty, full, 8'hAA, 1'b1, 1'b0);
        for (int i = 1; i <= 15; i++) cyc(1'b1, 8'(i), 1'b0);
        cyc(1'b1, 8'h5A, 1'b0);
        check("R7 hold through full write", data_out, empty, full, 8'hAA, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 1'b1);
        check("R9 next read", data_out, empty, full, 8'h01, 1'b0, 1'b0);
        cyc(1'b1, 8'h77, 1'b1);
        check("R8 read+write latched", data_out, empty, full, 8'h02, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule